// File: doc/BRIEF.md
# Error-Control Register with Tag-Array Access

This unit is a small slice of a system-control coprocessor. It holds a three-field error-control register and a 64-bit tag-low staging register. It also owns a compact local array of configuration tags for inter-thread communication. The error-control fields decide a single mode flag, tag-access mode. While the flag is clear, cache-maintenance requests are accepted and then dropped, and writes to tag-low pass through a fixed mask. While the flag is set, tag-low becomes fully writable. An index-store-tag request then copies tag-low into the array, and an index-load-tag request copies an array entry back into tag-low.

Software reaches both registers through a plain register port: a register number, a select, write data, a write strobe and a read strobe, with combinational read data. Cache-maintenance requests enter on a valid/ready channel. A request is taken on any rising edge where `cop_valid` and `cop_ready` are both high. `cop_ready` drops for exactly one cycle after a load-tag is taken, while the array read finishes. The sender must then hold the request stable until it sees ready. Register accesses have no back-pressure.

Top module: `errctl_tag_unit`

## Requirements
- R1: The error-control register is register 26, select 0. Only bit 29 (way-select), bit 28 (scratch) and bit 26 (tag enable) keep a written value. Every other bit reads back as 0.
- R2: When the parameter `TAG_PRESENT` is 0, bit 26 of error-control always reads 0, whatever value is written.
- R3: Tag-access mode is on exactly when bit 26 is 1 and bits 29 and 28 are both 0. It is recomputed on every error-control write. A cache request taken in the same cycle as that write already uses the new mode.
- R4: Tag-low is register 28, select 0. Outside tag-access mode a write stores `wdata & 64'h0000_0000_FFFF_FCF6`. Inside tag-access mode all 64 bits are stored.
- R5: Outside tag-access mode a cache request is accepted but changes neither tag-low nor the array.
- R6: In tag-access mode, op code 9 writes tag-low into the addressed array entry. Bits set in `TAG_RO_MASK` (default `64'hFF`) keep the entry's previous value.
- R7: In tag-access mode, op code 5 loads the addressed entry into tag-low on the edge after the request is taken, and `cop_ready` is low for that one cycle. Every other op code has no effect.
- R8: The array index is the address ANDed with `32'h1FFF_FFFF`, then bits [6:3] of the result select one of 16 entries. Address bits 31..29 are therefore ignored.
- R9: An access (read or write) to register 26 with a select other than 0 raises `illegal_sel` for exactly the following cycle, and leaves error-control unchanged.
- R10: After reset, error-control, tag-low, the mode flag and every array entry are 0, `cop_ready` is 1 and `illegal_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_num | input | 5 | Register number |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Combinational register read data |
| illegal_sel | output | 1 | One-cycle pulse after an unimplemented select of register 26 |
| cop_valid | input | 1 | Cache request valid |
| cop_ready | output | 1 | Cache request can be taken |
| cop_code | input | 5 | Cache operation code |
| cop_addr | input | 32 | Effective address of the cache request |

## Verification
Register writes take effect at the next rising edge, so read data is sampled combinationally one nanosecond after the following falling edge. `illegal_sel` is due in the cycle after the offending access. The bench samples it high at the first falling edge after that access and low at the second. A load-tag lands in tag-low one edge after the request is taken. The bench therefore checks that `cop_ready` is low at the falling edge right after acceptance, and reads tag-low only after one more edge. The same-cycle case drives an error-control write and a store-tag on the same edge. It then reads the entry back to prove the new mode was used.

// File: rtl/ectl_pkg.sv
package ectl_pkg;
  localparam int unsigned REG_NUM_W   = 5;
  localparam int unsigned REG_SEL_W   = 3;
  localparam int unsigned OP_W        = 5;

  localparam logic [REG_NUM_W-1:0] ERRCTL_NUM = 5'd26;
  localparam logic [REG_NUM_W-1:0] TAGLO_NUM  = 5'd28;

  localparam int unsigned BIT_WAYSEL = 29;
  localparam int unsigned BIT_SCRAT  = 28;
  localparam int unsigned BIT_TAGEN  = 26;

  localparam logic [31:0] ERRCTL_KEEP = (32'd1 << BIT_WAYSEL) |
                                        (32'd1 << BIT_SCRAT)  |
                                        (32'd1 << BIT_TAGEN);
  localparam logic [63:0] TAGLO_NORMAL_MASK = 64'h0000_0000_FFFF_FCF6;
  localparam logic [31:0] INDEX_ADDR_MASK   = 32'h1FFF_FFFF;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD_TAG  = 5'd5,
    OP_STORE_TAG = 5'd9
  } tag_op_e;

  function automatic logic tag_mode_of(input logic [31:0] ec);
    return ec[BIT_TAGEN] & ~ec[BIT_WAYSEL] & ~ec[BIT_SCRAT];
  endfunction
endpackage

// File: rtl/ectl_ctrl.sv
module ectl_ctrl
  import ectl_pkg::*;
#(
  parameter bit TAG_PRESENT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [REG_NUM_W-1:0] reg_num,
  input  logic [REG_SEL_W-1:0] reg_sel,
  input  logic [31:0]          wdata,
  output logic [31:0]          errctl_q,
  output logic                 mode_q,
  output logic                 mode_eff,
  output logic                 illegal_q
);
  logic        hit;
  logic        wr_ok;
  logic        bad_sel;
  logic [31:0] field_next;
  logic        mode_next;

  assign hit     = (reg_num == ERRCTL_NUM);
  assign wr_ok   = reg_wr && hit && (reg_sel == '0);
  assign bad_sel = (reg_wr || reg_rd) && hit && (reg_sel != '0);

  generate
    if (TAG_PRESENT) begin : g_with_tags
      assign field_next = wdata & ERRCTL_KEEP;
    end else begin : g_no_tags
      assign field_next = wdata & ERRCTL_KEEP & ~(32'd1 << BIT_TAGEN);
    end
  endgenerate

  assign mode_next = tag_mode_of(field_next);
  assign mode_eff  = wr_ok ? mode_next : mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      errctl_q  <= '0;
      mode_q    <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= bad_sel;
      if (wr_ok) begin
        errctl_q <= field_next;
        mode_q   <= mode_next;
      end
    end
  end
endmodule

// File: rtl/ectl_tagmem.sv
module ectl_tagmem #(
  parameter int unsigned ENTRIES     = 16,
  parameter int unsigned DATA_W      = 64,
  parameter logic [63:0] TAG_RO_MASK = 64'hFF,
  localparam int unsigned IDX_W      = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_en,
  input  logic              ld_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] st_data,
  output logic [DATA_W-1:0] ld_data
);
  logic [DATA_W-1:0] entry_q [ENTRIES];
  logic [DATA_W-1:0] ro_bits;

  assign ro_bits = TAG_RO_MASK[DATA_W-1:0];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        entry_q[e] <= '0;
      end else if (st_en && (idx == IDX_W'(e))) begin
        entry_q[e] <= (entry_q[e] & ro_bits) | (st_data & ~ro_bits);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_data <= '0;
    end else if (ld_en) begin
      ld_data <= entry_q[idx];
    end
  end
endmodule

// File: rtl/ectl_dispatch.sv
module ectl_dispatch
  import ectl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_eff,
  input  logic              cop_valid,
  output logic              cop_ready,
  input  logic [OP_W-1:0]   cop_code,
  input  logic [ADDR_W-1:0] cop_addr,
  output logic              st_en,
  output logic              ld_en,
  output logic              ld_pend_q,
  output logic [IDX_W-1:0]  idx
);
  logic              take;
  logic              act;
  logic [ADDR_W-1:0] masked;

  assign cop_ready = ~ld_pend_q;
  assign take      = cop_valid & cop_ready;
  assign act       = take & mode_eff;
  assign st_en     = act & (cop_code == OP_STORE_TAG);
  assign ld_en     = act & (cop_code == OP_LOAD_TAG);
  assign masked    = cop_addr & ADDR_W'(INDEX_ADDR_MASK);
  assign idx       = masked[3 +: IDX_W];

  logic unused_addr_bits;
  assign unused_addr_bits = ^{masked[ADDR_W-1:3+IDX_W], masked[2:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ld_pend_q <= 1'b0;
    else        ld_pend_q <= ld_en;
  end
endmodule

// File: rtl/errctl_tag_unit.sv
module errctl_tag_unit
  import ectl_pkg::*;
#(
  parameter bit          TAG_PRESENT = 1'b1,
  parameter int unsigned ENTRIES     = 16,
  parameter int unsigned ADDR_W      = 32,
  parameter logic [63:0] TAG_RO_MASK = 64'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [4:0]    reg_num,
  input  logic [2:0]    reg_sel,
  input  logic [63:0]   reg_wdata,
  output logic [63:0]   reg_rdata,
  output logic          illegal_sel,
  input  logic          cop_valid,
  output logic          cop_ready,
  input  logic [4:0]    cop_code,
  input  logic [ADDR_W-1:0] cop_addr
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);

  logic [31:0]      errctl_q;
  logic             mode_q;
  logic             mode_eff;
  logic             st_en;
  logic             ld_en;
  logic             ld_pend_q;
  logic [IDX_W-1:0] idx;
  logic [63:0]      ld_data;
  logic [63:0]      taglo_q;
  logic             taglo_wr;

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^reg_wdata[63:32];

  ectl_ctrl #(.TAG_PRESENT(TAG_PRESENT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_num(reg_num), .reg_sel(reg_sel), .wdata(reg_wdata[31:0]),
    .errctl_q(errctl_q), .mode_q(mode_q), .mode_eff(mode_eff),
    .illegal_q(illegal_sel)
  );

  ectl_dispatch #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_disp (
    .clk(clk), .rst_n(rst_n), .mode_eff(mode_eff),
    .cop_valid(cop_valid), .cop_ready(cop_ready),
    .cop_code(cop_code), .cop_addr(cop_addr),
    .st_en(st_en), .ld_en(ld_en), .ld_pend_q(ld_pend_q), .idx(idx)
  );

  ectl_tagmem #(.ENTRIES(ENTRIES), .DATA_W(64), .TAG_RO_MASK(TAG_RO_MASK)) u_mem (
    .clk(clk), .rst_n(rst_n), .st_en(st_en), .ld_en(ld_en),
    .idx(idx), .st_data(taglo_q), .ld_data(ld_data)
  );

  assign taglo_wr = reg_wr && (reg_num == TAGLO_NUM) && (reg_sel == '0);

  // A finishing load-tag takes priority over a software write in the same edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taglo_q <= '0;
    end else if (ld_pend_q) begin
      taglo_q <= ld_data;
    end else if (taglo_wr) begin
      taglo_q <= mode_q ? reg_wdata : (reg_wdata & TAGLO_NORMAL_MASK);
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_sel == '0) begin
      if (reg_num == ERRCTL_NUM)     reg_rdata = {32'd0, errctl_q};
      else if (reg_num == TAGLO_NUM) reg_rdata = taglo_q;
    end
  end
endmodule

// File: rtl/ectl_checker.sv
module ectl_checker #(
  parameter bit TAG_PRESENT = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic [4:0]  reg_num,
  input logic [2:0]  reg_sel,
  input logic [63:0] reg_rdata,
  input logic        illegal_sel,
  input logic        cop_valid,
  input logic        cop_ready,
  input logic [4:0]  cop_code,
  input logic        mode_q,
  input logic        mode_eff,
  input logic        ld_pend_q,
  input logic [63:0] taglo_q
);
  assert_errctl_fields_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_num == 5'd26 && reg_sel == 3'd0) |-> ((reg_rdata & ~64'h3400_0000) == 64'd0));

  assert_no_tag_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!TAG_PRESENT && reg_num == 5'd26 && reg_sel == 3'd0) |-> !reg_rdata[26]);

  assert_taglo_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_num == 5'd28 && reg_sel == 3'd0 && !mode_q && !ld_pend_q)
      |=> ((taglo_q & ~64'h0000_0000_FFFF_FCF6) == 64'd0));

  assert_off_mode_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cop_valid && cop_ready && !mode_eff && !reg_wr && !ld_pend_q) |=> $stable(taglo_q));

  assert_load_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cop_valid && cop_ready && mode_eff && cop_code == 5'd5) |=> !cop_ready);

  assert_ready_recovers_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cop_ready |=> cop_ready);

  assert_illegal_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_wr || reg_rd) && reg_num == 5'd26 && reg_sel != 3'd0) |=> illegal_sel);

  assert_illegal_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !((reg_wr || reg_rd) && reg_num == 5'd26 && reg_sel != 3'd0) |=> !illegal_sel);
endmodule

bind errctl_tag_unit ectl_checker #(.TAG_PRESENT(TAG_PRESENT)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_num(reg_num), .reg_sel(reg_sel), .reg_rdata(reg_rdata),
  .illegal_sel(illegal_sel), .cop_valid(cop_valid), .cop_ready(cop_ready),
  .cop_code(cop_code), .mode_q(mode_q), .mode_eff(mode_eff),
  .ld_pend_q(ld_pend_q), .taglo_q(taglo_q)
);

// File: tb/tb_errctl_tag_unit.sv
module tb_errctl_tag_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0]  reg_num = '0;
  logic [2:0]  reg_sel = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata, nt_rdata;
  logic        illegal_sel, nt_illegal;
  logic        cop_valid = 1'b0;
  logic        cop_ready, nt_ready;
  logic [4:0]  cop_code = '0;
  logic [31:0] cop_addr = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  errctl_tag_unit dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_num(reg_num), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .illegal_sel(illegal_sel),
    .cop_valid(cop_valid), .cop_ready(cop_ready),
    .cop_code(cop_code), .cop_addr(cop_addr)
  );

  errctl_tag_unit #(.TAG_PRESENT(1'b0)) dut_nt (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_num(reg_num), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(nt_rdata), .illegal_sel(nt_illegal),
    .cop_valid(cop_valid), .cop_ready(nt_ready),
    .cop_code(cop_code), .cop_addr(cop_addr)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] n, input logic [2:0] s, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_num = n; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] n, input logic [2:0] s, output logic [63:0] d, output logic [63:0] dn);
    reg_num = n; reg_sel = s; reg_rd = 1'b1;
    #1;
    d = reg_rdata; dn = nt_rdata;
    reg_rd = 1'b0;
  endtask

  // One cache request; checks ready the cycle after acceptance, waits for completion.
  task automatic cop(input logic [4:0] code, input logic [31:0] a, input bit expect_stall, input string req);
    @(negedge clk);
    cop_valid = 1'b1; cop_code = code; cop_addr = a;
    @(negedge clk);
    cop_valid = 1'b0;
    #1;
    check(cop_ready == !expect_stall, req, {63'd0, cop_ready}, {63'd0, !expect_stall});
    @(negedge clk);
  endtask

  task automatic test_reset();
    logic [63:0] d, dn;
    rd_reg(5'd26, 3'd0, d, dn);
    check(d == 64'd0, "R10 errctl reset", d, 64'd0);
    rd_reg(5'd28, 3'd0, d, dn);
    check(d == 64'd0, "R10 taglo reset", d, 64'd0);
    check(illegal_sel == 1'b0 && cop_ready == 1'b1, "R10 outputs reset",
          {62'd0, illegal_sel, cop_ready}, 64'd1);
  endtask

  task automatic test_fields();
    logic [63:0] d, dn;
    wr_reg(5'd26, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_reg(5'd26, 3'd0, d, dn);
    check(d == 64'h3400_0000, "R1 only three fields kept", d, 64'h3400_0000);
    check(dn == 64'h3000_0000, "R2 tag bit forced low without array", dn, 64'h3000_0000);
    // all three set: mode off, taglo masked
    wr_reg(5'd28, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_reg(5'd28, 3'd0, d, dn);
    check(d == 64'h0000_0000_FFFF_FCF6, "R4 normal-mode taglo mask", d, 64'h0000_0000_FFFF_FCF6);
  endtask

  task automatic test_mode();
    logic [63:0] d, dn;
    wr_reg(5'd26, 3'd0, 64'h0400_0000);
    wr_reg(5'd28, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_reg(5'd28, 3'd0, d, dn);
    check(d == 64'hFFFF_FFFF_FFFF_FFFF, "R4 tag-mode taglo full width", d, 64'hFFFF_FFFF_FFFF_FFFF);
    check(dn == 64'h0000_0000_FFFF_FCF6, "R2 no array never enters tag mode", dn, 64'h0000_0000_FFFF_FCF6);
    wr_reg(5'd26, 3'd0, 64'h1400_0000);
    wr_reg(5'd28, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_reg(5'd28, 3'd0, d, dn);
    check(d == 64'h0000_0000_FFFF_FCF6, "R3 scratch bit cancels tag mode", d, 64'h0000_0000_FFFF_FCF6);
  endtask

  task automatic test_store_load();
    logic [63:0] d, dn;
    wr_reg(5'd26, 3'd0, 64'h0400_0000);
    wr_reg(5'd28, 3'd0, 64'h1122_3344_5566_7788);
    cop(5'd9, 32'h0000_0018, 1'b0, "R6 store no stall");
    wr_reg(5'd28, 3'd0, 64'd0);
    cop(5'd5, 32'hE000_0018, 1'b1, "R7 ready low after load");
    rd_reg(5'd28, 3'd0, d, dn);
    check(d == 64'h1122_3344_5566_7700, "R6 R8 stored entry with read-only byte", d, 64'h1122_3344_5566_7700);
    cop(5'd1, 32'h0000_0018, 1'b0, "R7 other op no stall");
    rd_reg(5'd28, 3'd0, d, dn);
    check(d == 64'h1122_3344_5566_7700, "R7 other op leaves taglo", d, 64'h1122_3344_5566_7700);
    cop(5'd5, 32'h0000_0058, 1'b1, "R8 load stall");
    rd_reg(5'd28, 3'd0, d, dn);
    check(d == 64'd0, "R8 address bit 6 selects a different entry", d, 64'd0);
  endtask

  task automatic test_off_mode();
    logic [63:0] d, dn;
    wr_reg(5'd26, 3'd0, 64'd0);
    wr_reg(5'd28, 3'd0, 64'h0000_0000_AAAA_5555);
    cop(5'd9, 32'h0000_0020, 1'b0, "R5 store accepted off");
    cop(5'd5, 32'h0000_0018, 1'b0, "R5 load no stall off");
    rd_reg(5'd28, 3'd0, d, dn);
    check(d == 64'h0000_0000_AAAA_5454, "R5 load ignored off", d, 64'h0000_0000_AAAA_5454);
    wr_reg(5'd26, 3'd0, 64'h0400_0000);
    wr_reg(5'd28, 3'd0, 64'd0);
    cop(5'd5, 32'h0000_0020, 1'b1, "R5 readback stall");
    rd_reg(5'd28, 3'd0, d, dn);
    check(d == 64'd0, "R5 store ignored off", d, 64'd0);
  endtask

  task automatic test_same_cycle();
    logic [63:0] d, dn;
    wr_reg(5'd26, 3'd0, 64'd0);
    wr_reg(5'd28, 3'd0, 64'h0000_0000_CAFE_F0F0);
    @(negedge clk);
    reg_wr = 1'b1; reg_num = 5'd26; reg_sel = 3'd0; reg_wdata = 64'h0400_0000;
    cop_valid = 1'b1; cop_code = 5'd9; cop_addr = 32'h0000_0028;
    @(negedge clk);
    reg_wr = 1'b0; cop_valid = 1'b0;
    wr_reg(5'd28, 3'd0, 64'd0);
    cop(5'd5, 32'h0000_0028, 1'b1, "R3 readback stall");
    rd_reg(5'd28, 3'd0, d, dn);
    check(d == 64'h0000_0000_CAFE_F000, "R3 same-cycle write sets mode for store", d, 64'h0000_0000_CAFE_F000);
  endtask

  task automatic test_illegal();
    logic [63:0] d, dn;
    @(negedge clk);
    reg_wr = 1'b1; reg_num = 5'd26; reg_sel = 3'd1; reg_wdata = 64'd0;
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = 3'd0;
    #1;
    check(illegal_sel == 1'b1, "R9 pulse after bad select", {63'd0, illegal_sel}, 64'd1);
    @(negedge clk);
    #1;
    check(illegal_sel == 1'b0, "R9 pulse lasts one cycle", {63'd0, illegal_sel}, 64'd0);
    rd_reg(5'd26, 3'd0, d, dn);
    check(d == 64'h0400_0000, "R9 bad select write ignored", d, 64'h0400_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_fields();
    test_mode();
    test_store_load();
    test_off_mode();
    test_same_cycle();
    test_illegal();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule